// File: doc/BRIEF.md
# Zero-Suppressed Pixel Column Readout with Token Passing

This block holds the digital state of one column of pixel cells and reports only the pixels that hold a hit. Each cell latches a hit from its discriminator or from a test-inject control. A per-cell kill bit can silence the cell. When the cell latches a hit, it converts its seven amplitude comparators into a 3-bit code. In the same clock edge it copies the beam-crossing counter value. Every cell hit at one edge therefore carries the same counter value.

A token enters the column from the previous column. While the column is in read mode and the token is present, the lowest-numbered hit row drives the bus for one clock. That row then clears itself. A pending-hit flag stays high while any unread hit remains. When nothing is pending, the token passes straight to the next column in the same cycle, so columns can be chained.

A two-bit command selects the operating mode. The controller registers the command into a state:
- ST_IDLE: nothing is captured and nothing is read.
- ST_FLUSH: all hits are cleared.
- ST_DRAIN: hits are read out and capture continues.
- ST_ARM: hits are captured only.

Every state moves to the state that matches the command sampled at each clock edge. The new state acts from the following edge.

Top module: `pxcol_readout`

## Requirements
- R1: While reset is low, and after its release, `rd_valid` and `fast_or` are 0.
- R2: Command encoding is 00 idle, 01 clear, 10 read, 11 listen. Hits are captured only in listen or read. The clear command empties every cell, so `fast_or` is 0 after it.
- R3: A word is produced only for a cell holding a hit, at most one per clock. Pending hits are read in ascending row order.
- R4: The word layout is row in bits [17:11], amplitude in [10:8] and timestamp in [7:0].
- R5: The amplitude is the index plus one of the highest asserted comparator (bit k gives k+1). No asserted comparator gives 0, and a non-monotonic pattern still uses the highest asserted bit.
- R6: Every cell hit at the same clock edge stores the `bco` value sampled at that edge. Later counter changes do not alter the stored value.
- R7: A cell whose kill bit is set never latches a hit and never produces a word.
- R8: The inject control latches a hit exactly as the discriminator does.
- R9: `fast_or` is 1 exactly while at least one unread hit is held.
- R10: `tok_out` equals `tok_in` in the same cycle when no hit is pending, and is 0 otherwise. A read happens only while `tok_in` is 1 in read mode.
- R11: While `tok_rst` is 1, `tok_out` is 0 and no word is read.
- R12: A hit arriving at a cell that already holds an unread hit is ignored, and the first amplitude and timestamp are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Read reset, active low |
| mode | input | 2 | Command: 00 idle, 01 clear, 10 read, 11 listen |
| bco | input | 8 | Beam-crossing counter |
| disc | input | 128 | Per-row hit discriminator |
| inject | input | 128 | Per-row test inject |
| kill | input | 128 | Per-row kill bit |
| therm | input | 896 | Seven comparator outputs per row, row r at bits [7r+6:7r] |
| tok_in | input | 1 | Token from previous column |
| tok_rst | input | 1 | Token reset |
| tok_out | output | 1 | Token to next column |
| fast_or | output | 1 | Any unread hit pending |
| rd_valid | output | 1 | Word on `rd_word` is valid |
| rd_word | output | 18 | {row, amplitude, timestamp} |

## Verification
The hardest case is a group of cells hit at one edge while the counter moves on the very next edge, mixed with a retrigger of an already-hit cell, a killed cell and an injected cell. The bench pulses these hits for single clocks with distinct counter values. It then holds the token off, and later under token reset, before letting the column drain. This checks that every word keeps its capture-edge timestamp and comes out in row order. A second burst hits eight adjacent rows in one cycle with a staircase of comparator patterns.

// File: rtl/pxcol_pkg.sv
package pxcol_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE   = 2'b00,
        CMD_CLEAR  = 2'b01,
        CMD_READ   = 2'b10,
        CMD_LISTEN = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FLUSH,
        ST_DRAIN,
        ST_ARM
    } st_e;
endpackage

// File: rtl/pxcol_therm_enc.sv
module pxcol_therm_enc #(
    parameter int LVL   = 7,
    parameter int ADC_W = $clog2(LVL + 1)
) (
    input  logic [LVL-1:0]   therm,
    output logic [ADC_W-1:0] code
);
    // highest asserted comparator wins, so bubbles below it are ignored
    always_comb begin
        code = '0;
        for (int k = 0; k < LVL; k++) begin
            if (therm[k]) code = ADC_W'(k + 1);
        end
    end
endmodule

// File: rtl/pxcol_cell.sv
module pxcol_cell #(
    parameter int LVL   = 7,
    parameter int TS_W  = 8,
    parameter int ADC_W = $clog2(LVL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             clr_all,
    input  logic             rd_clr,
    input  logic             disc,
    input  logic             inj,
    input  logic             kill,
    input  logic [LVL-1:0]   therm,
    input  logic [TS_W-1:0]  bco,
    output logic             hit,
    output logic [ADC_W-1:0] adc,
    output logic [TS_W-1:0]  ts
);
    logic [ADC_W-1:0] code;

    pxcol_therm_enc #(.LVL(LVL), .ADC_W(ADC_W)) u_enc (
        .therm (therm),
        .code  (code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit <= 1'b0;
            adc <= '0;
            ts  <= '0;
        end else if (clr_all || rd_clr) begin
            hit <= 1'b0;
        end else if (cap_en && (disc || inj) && !kill && !hit) begin
            hit <= 1'b1;
            adc <= code;
            ts  <= bco;
        end
    end
endmodule

// File: rtl/pxcol_first.sv
module pxcol_first #(
    parameter int N   = 128,
    parameter int IDX = $clog2(N)
) (
    input  logic [N-1:0]   req,
    output logic [N-1:0]   gnt,
    output logic [IDX-1:0] idx,
    output logic           any
);
    // isolate the lowest set bit
    assign gnt = req & (~req + N'(1));
    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i]) idx = idx | IDX'(i);
        end
    end
endmodule

// File: rtl/pxcol_ctrl.sv
module pxcol_ctrl
    import pxcol_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       tok_in,
    input  logic       tok_rst,
    input  logic       any_hit,
    output st_e        st,
    output logic       cap_en,
    output logic       clr_all,
    output logic       rd_go,
    output logic       tok_out
);
    st_e st_nx;

    always_comb begin
        unique case (cmd_e'(mode))
            CMD_IDLE:   st_nx = ST_IDLE;
            CMD_CLEAR:  st_nx = ST_FLUSH;
            CMD_READ:   st_nx = ST_DRAIN;
            CMD_LISTEN: st_nx = ST_ARM;
            default:    st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        cap_en  = 1'b0;
        clr_all = 1'b0;
        rd_go   = 1'b0;
        unique case (st)
            ST_IDLE:  ;
            ST_FLUSH: clr_all = 1'b1;
            ST_ARM:   cap_en  = 1'b1;
            ST_DRAIN: begin
                cap_en = 1'b1;
                rd_go  = tok_in && !tok_rst && any_hit;
            end
            default:  ;
        endcase
        tok_out = tok_in && !tok_rst && !any_hit;
    end
endmodule

// File: rtl/pxcol_readout.sv
module pxcol_readout
    import pxcol_pkg::*;
#(
    parameter int ROWS = 128,
    parameter int LVL  = 7,
    parameter int TS_W = 8,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADC_W  = $clog2(LVL + 1),
    localparam int WORD_W = ROW_W + ADC_W + TS_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          mode,
    input  logic [TS_W-1:0]     bco,
    input  logic [ROWS-1:0]     disc,
    input  logic [ROWS-1:0]     inject,
    input  logic [ROWS-1:0]     kill,
    input  logic [ROWS*LVL-1:0] therm,
    input  logic                tok_in,
    input  logic                tok_rst,
    output logic                tok_out,
    output logic                fast_or,
    output logic                rd_valid,
    output logic [WORD_W-1:0]   rd_word
);
    st_e              st;
    logic             cap_en, clr_all, rd_go, any_hit;
    logic [ROWS-1:0]  hit_v, gnt;
    logic [ROW_W-1:0] row_idx;
    logic [ADC_W-1:0] adc_a [ROWS];
    logic [TS_W-1:0]  ts_a  [ROWS];
    logic [ADC_W-1:0] adc_sel;
    logic [TS_W-1:0]  ts_sel;

    pxcol_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .tok_in  (tok_in),
        .tok_rst (tok_rst),
        .any_hit (any_hit),
        .st      (st),
        .cap_en  (cap_en),
        .clr_all (clr_all),
        .rd_go   (rd_go),
        .tok_out (tok_out)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_cell
        pxcol_cell #(.LVL(LVL), .TS_W(TS_W), .ADC_W(ADC_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap_en  (cap_en),
            .clr_all (clr_all),
            .rd_clr  (rd_go && gnt[r]),
            .disc    (disc[r]),
            .inj     (inject[r]),
            .kill    (kill[r]),
            .therm   (therm[r*LVL +: LVL]),
            .bco     (bco),
            .hit     (hit_v[r]),
            .adc     (adc_a[r]),
            .ts      (ts_a[r])
        );
    end

    pxcol_first #(.N(ROWS), .IDX(ROW_W)) u_first (
        .req (hit_v),
        .gnt (gnt),
        .idx (row_idx),
        .any (any_hit)
    );

    always_comb begin
        adc_sel = '0;
        ts_sel  = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (gnt[i]) begin
                adc_sel = adc_sel | adc_a[i];
                ts_sel  = ts_sel  | ts_a[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_word  <= '0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go) rd_word <= {row_idx, adc_sel, ts_sel};
        end
    end

    assign fast_or = any_hit;
endmodule

// File: rtl/pxcol_readout_chk.sv
module pxcol_readout_chk
    import pxcol_pkg::*;
#(
    parameter int ROWS = 128
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tok_in,
    input logic            tok_rst,
    input logic            tok_out,
    input logic            fast_or,
    input logic            rd_valid,
    input st_e             st,
    input logic [ROWS-1:0] gnt
);
    assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> !rd_valid);

    assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FLUSH) |=> !fast_or);

    assert_single_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_nothing_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_or |=> !rd_valid);

    assert_read_needs_token_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(tok_in && !tok_rst && st == ST_DRAIN));

    assert_tokrst_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tok_rst |=> !rd_valid);

    assert_tokrst_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tok_rst |-> !tok_out);
endmodule

bind pxcol_readout pxcol_readout_chk #(.ROWS(ROWS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tok_in   (tok_in),
    .tok_rst  (tok_rst),
    .tok_out  (tok_out),
    .fast_or  (fast_or),
    .rd_valid (rd_valid),
    .st       (st),
    .gnt      (gnt)
);

// File: tb/test_pxcol_readout.sv
`timescale 1ns/1ps
module test_pxcol_readout;
    localparam int ROWS = 128, LVL = 7, TS_W = 8, WW = 18;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          mode = 2'b00;
    logic [TS_W-1:0]     bco = '0;
    logic [ROWS-1:0]     disc = '0, inject = '0, kill = '0;
    logic [ROWS*LVL-1:0] therm = '0;
    logic                tok_in = 1'b0, tok_rst = 1'b0;
    logic                tok_out, fast_or, rd_valid;
    logic [WW-1:0]       rd_word;

    int checks = 0, errors = 0, words = 0;
    bit done = 0;
    logic [WW-1:0] expq[$];

    always #2.5 clk = ~clk;

    pxcol_readout i_pxcol_readout (
        .clk(clk), .rst_n(rst_n), .mode(mode), .bco(bco), .disc(disc),
        .inject(inject), .kill(kill), .therm(therm), .tok_in(tok_in),
        .tok_rst(tok_rst), .tok_out(tok_out), .fast_or(fast_or),
        .rd_valid(rd_valid), .rd_word(rd_word)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int row, input int adc, input int ts);
        expq.push_back({7'(row), 3'(adc), 8'(ts)});
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode = m;
        repeat (2) @(negedge clk);
    endtask

    // monitor: compare each produced word with the queue head
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            words++;
            if (expq.size() == 0) begin
                chk(0, "R3 unexpected word", int'(rd_word), 0);
            end else begin
                logic [WW-1:0] e;
                e = expq.pop_front();
                chk(rd_word[17:11] == e[17:11], "R3 row order", rd_word[17:11], e[17:11]);
                chk(rd_word[10:8] == e[10:8], "R5 amplitude", rd_word[10:8], e[10:8]);
                chk(rd_word[7:0] == e[7:0], "R6 timestamp", rd_word[7:0], e[7:0]);
            end
        end
    end

    task automatic drain();
        for (int i = 0; i < 300 && expq.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(expq.size() == 0, "R3 all words produced", expq.size(), 0);
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rd_valid == 0 && fast_or == 0, "R1 in reset", {rd_valid, fast_or}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        tok_in = 1'b1;
        #1;
        chk(fast_or == 0 && rd_valid == 0, "R1 after reset", {rd_valid, fast_or}, 0);
        chk(tok_out == 1, "R10 token passes empty column", tok_out, 1);
        tok_in = 1'b0;

        // R2: idle ignores hits
        @(negedge clk); disc[5] = 1'b1;
        @(negedge clk); disc = '0;
        @(negedge clk);
        chk(fast_or == 0, "R2 idle captures nothing", fast_or, 0);

        // main burst in listen mode
        set_mode(2'b11);
        bco = 8'h11;
        disc[3] = 1; therm[3*7 +: 7] = 7'h7F;
        disc[40] = 1; therm[40*7 +: 7] = 7'h01;
        disc[127] = 1; therm[127*7 +: 7] = 7'b0100101;
        inject[90] = 1; therm[90*7 +: 7] = 7'h07;
        disc[60] = 1; kill[60] = 1; therm[60*7 +: 7] = 7'h3F;
        @(negedge clk);
        disc = '0; inject = '0; bco = 8'h12;
        disc[3] = 1; therm[3*7 +: 7] = 7'h01;
        disc[10] = 1; therm[10*7 +: 7] = 7'h00;
        @(negedge clk);
        disc = '0; bco = 8'h13;
        push(3, 7, 8'h11);    // R12 retrigger ignored, R5 all set
        push(10, 0, 8'h12);   // R5 none set, R6 second edge
        push(40, 1, 8'h11);
        push(90, 3, 8'h11);   // R8 inject
        push(127, 6, 8'h11);  // R5 non-monotonic; row 60 killed (R7)
        tok_in = 1'b1;
        #1;
        chk(fast_or == 1, "R9 hits pending", fast_or, 1);
        chk(tok_out == 0, "R10 token held while pending", tok_out, 0);
        tok_in = 1'b0;

        set_mode(2'b10);
        repeat (3) @(negedge clk);
        chk(expq.size() == 5, "R10 no read without token", expq.size(), 5);
        tok_rst = 1'b1; tok_in = 1'b1;
        #1;
        chk(tok_out == 0, "R11 token reset holds token", tok_out, 0);
        repeat (3) @(negedge clk);
        chk(expq.size() == 5, "R11 no read under token reset", expq.size(), 5);
        tok_rst = 1'b0;
        drain();
        chk(words == 5, "R7 killed row not reported", words, 5);
        chk(fast_or == 0, "R9 flag drops after drain", fast_or, 0);
        #1;
        chk(tok_out == 1, "R10 token passes after drain", tok_out, 1);
        tok_in = 1'b0;

        // R2 clear command
        set_mode(2'b11);
        disc[20] = 1; disc[21] = 1;
        @(negedge clk); disc = '0;
        @(negedge clk);
        chk(fast_or == 1, "R2 listen captures", fast_or, 1);
        set_mode(2'b01);
        chk(fast_or == 0, "R2 clear empties column", fast_or, 0);
        set_mode(2'b10);
        tok_in = 1'b1;
        repeat (4) @(negedge clk);
        chk(words == 5, "R2 nothing after clear", words, 5);
        tok_in = 1'b0;

        // R6/R4: eight rows hit at one edge, counter moves right after
        set_mode(2'b11);
        bco = 8'hA5;
        for (int r = 0; r < 8; r++) begin
            disc[r] = 1'b1;
            therm[r*7 +: 7] = 7'((1 << r) - 1);
            push(r, r, 8'hA5);
        end
        @(negedge clk);
        disc = '0; bco = 8'hA6;
        @(negedge clk); bco = 8'hA7;
        set_mode(2'b10);
        tok_in = 1'b1;
        drain();
        chk(words == 13, "R4 burst word count", words, 13);
        tok_in = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule